// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It does so by reading one 64-bit descriptor from each of four nested translation tables in memory. A request carries the virtual address, the kind of access (read, write or instruction fetch) and whether the requester runs in user mode. A root input gives the frame of the top table. Each descriptor found supplies the frame of the next table, or of the final page.

On the way down, the walker gathers the permission bits of all four levels. It stops with a fault code as soon as a descriptor is absent, a permission is refused, or the top descriptor asks for a large page. For each descriptor that passes its checks, the walker writes back the accessed flag, and on a write access the dirty flag of the last descriptor. It does this only when the stored value would change.

Only one walk runs at a time. The memory side is a single valid/ready request channel, used for both reads and writes, plus a read-data strobe. A walk ends with a one-cycle response that carries either the physical address or a fault code.

Top module: `page_walker`

## Requirements
- R1: The descriptor for level k (k = 0 first) is read from address {table frame, index field k, 3'b000}. Index field 0 is vaddr[47:39], field 1 is vaddr[38:30], field 2 is vaddr[29:21] and field 3 is vaddr[20:12]. The level-0 table frame is `rootBase`. The frame of each later table is bits [51:12] of the previous descriptor.
- R2: A walk without fault responds with fault code 0 and physical address {level-3 descriptor bits [51:12], vaddr[11:0]}.
- R3: A descriptor with bit 0 (present) clear ends the walk with fault code 1. No further memory request is made for that walk.
- R4: A write access (reqAccess = 1) faults with code 2 if bit 1 (writable) is clear in any descriptor reached so far.
- R5: A user-mode access (reqUser = 1) faults with code 2 if bit 2 (user-allowed) is clear in any descriptor reached so far.
- R6: An instruction fetch (reqAccess = 2) faults with code 2 if bit 63 (no-execute) is set in any descriptor reached so far.
- R7: Bit 7 (large page) set in the level-0 descriptor ends the walk with fault code 3. In the descriptors of levels 1 to 3, bit 7 has no effect.
- R8: Every descriptor that passes its checks is written back to its own address with bit 5 (accessed) set. The write happens only if that bit, or the dirty bit of R9, was not already set.
- R9: On a write access, bit 6 (dirty) is set in the level-3 descriptor write-back. On any other access, bit 6 is never set by the walker.
- R10: A descriptor that causes a fault is never written. Descriptors of earlier levels keep their updates.
- R11: `reqReady` is high only while idle. A request is accepted only then. `respValid` is a one-cycle pulse, after which the walker is idle again.
- R12: A memory request holds `memValid`, `memWrite`, `memAddr` and `memWdata` stable until `memReady` is seen. Read data is taken only on `memRvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 48 | Virtual address to translate |
| reqAccess | input | 2 | 0 read, 1 write, 2 instruction fetch |
| reqUser | input | 1 | 1 for user-mode access |
| rootBase | input | 40 | Frame of the top-level table |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts request |
| memWrite | output | 1 | 1 write, 0 read |
| memAddr | output | 52 | Descriptor byte address |
| memWdata | output | 64 | Updated descriptor for write-back |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 64 | Descriptor read from memory |
| respValid | output | 1 | Walk finished, one cycle |
| respPaddr | output | 52 | Translated address, valid when fault code is 0 |
| respFault | output | 2 | 0 none, 1 not present, 2 protection, 3 large page |

## Verification
The assertions rely on the memory side behaving in a fixed way. It returns exactly one `memRvalid` pulse per accepted read, at least one cycle after the handshake. It never pulses `memRvalid` while no read is outstanding. `rootBase` stays unchanged during a walk.

The bench memory model obeys these rules. It queues a single read with a delay of one to three cycles and drops `memReady` on a pseudo-random pattern. It places the four tables in distinct frames, so that descriptors never alias.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER = 2;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY = 6;
  localparam int BIT_BIGPAGE = 7;
  localparam int BIT_NOEXEC = 63;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT = 2'd2,
    FLT_BIGPAGE = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } access_e;

  typedef struct packed {
    logic loadReq;
    logic loadEntry;
    logic stepLevel;
  } strobe_t;

  typedef struct packed {
    logic present;
    logic bigPage;
    logic denied;
    logic needWb;
    logic lastLevel;
  } flags_t;

endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PTE_W = 64,
  parameter int VA_W = OFF_W + LEVELS * IDX_W,
  parameter int PA_W = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              reqUser,
  input  logic [PA_W-OFF_W-1:0] rootBase,
  input  logic [PTE_W-1:0]  memRdata,
  output flags_t            flags,
  output logic [PA_W-1:0]   memAddr,
  output logic [PTE_W-1:0]  memWdata,
  output logic [PA_W-1:0]   respPaddr
);

  localparam int BASE_W = PA_W - OFF_W;
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  logic [VA_W-1:0]   vaddrQ;
  logic [1:0]        accessQ;
  logic              userQ;
  logic [BASE_W-1:0] tableBase;
  logic [PTE_W-1:0]  entryQ;
  logic [LVL_W-1:0]  level;
  logic              rwAcc, usAcc, xAcc;

  logic [IDX_W-1:0]  idx;
  logic [PTE_W-1:0]  updEntry;
  logic              effRw, effUs, effX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      accessQ <= '0;
      userQ <= 1'b0;
      tableBase <= '0;
      entryQ <= '0;
      level <= '0;
      rwAcc <= 1'b1;
      usAcc <= 1'b1;
      xAcc <= 1'b1;
    end else begin
      if (strobe.loadReq) begin
        vaddrQ <= reqVaddr;
        accessQ <= reqAccess;
        userQ <= reqUser;
        tableBase <= rootBase;
        level <= '0;
        rwAcc <= 1'b1;
        usAcc <= 1'b1;
        xAcc <= 1'b1;
      end
      if (strobe.loadEntry) entryQ <= memRdata;
      if (strobe.stepLevel) begin
        level <= level + 1'b1;
        tableBase <= entryQ[PA_W-1:OFF_W];
        rwAcc <= effRw;
        usAcc <= effUs;
        xAcc <= effX;
      end
    end
  end

  always_comb begin
    int shamt;
    shamt = OFF_W + (LEVELS - 1 - int'(level)) * IDX_W;
    idx = vaddrQ[shamt +: IDX_W];
  end

  assign effRw = rwAcc & entryQ[BIT_WRITABLE];
  assign effUs = usAcc & entryQ[BIT_USER];
  assign effX = xAcc & ~entryQ[BIT_NOEXEC];

  always_comb begin
    updEntry = entryQ;
    updEntry[BIT_ACCESSED] = 1'b1;
    if (level == LAST_LVL && accessQ == ACC_WRITE) updEntry[BIT_DIRTY] = 1'b1;
  end

  assign flags.present = entryQ[BIT_PRESENT];
  assign flags.bigPage = (level == '0) && entryQ[BIT_BIGPAGE];
  assign flags.denied = (accessQ == ACC_WRITE && !effRw) ||
                        (userQ && !effUs) ||
                        (accessQ == ACC_FETCH && !effX);
  assign flags.needWb = (updEntry != entryQ);
  assign flags.lastLevel = (level == LAST_LVL);

  assign memAddr = {tableBase, idx, {ENT_SH{1'b0}}};
  assign memWdata = updEntry;
  assign respPaddr = {entryQ[PA_W-1:OFF_W], vaddrQ[OFF_W-1:0]};

  AST_NO_STEP_PAST_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepLevel |-> level != LAST_LVL) else $error("step beyond last level"); // R2

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       memReady,
  input  logic       memRvalid,
  output logic       memValid,
  output logic       memWrite,
  input  flags_t     flags,
  output strobe_t    strobe,
  output logic       respValid,
  output logic [1:0] respFault
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EVAL,
    ST_UPDATE,
    ST_FINISH
  } state_e;

  state_e state, stateNext;
  fault_e faultQ, faultNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      faultQ <= FLT_NONE;
    end else begin
      state <= stateNext;
      faultQ <= faultNext;
    end
  end

  always_comb begin
    stateNext = state;
    faultNext = faultQ;
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          faultNext = FLT_NONE;
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRvalid) begin
          strobe.loadEntry = 1'b1;
          stateNext = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!flags.present) begin
          faultNext = FLT_ABSENT;
          stateNext = ST_FINISH;
        end else if (flags.bigPage) begin
          faultNext = FLT_BIGPAGE;
          stateNext = ST_FINISH;
        end else if (flags.denied) begin
          faultNext = FLT_PROT;
          stateNext = ST_FINISH;
        end else if (flags.needWb) begin
          stateNext = ST_UPDATE;
        end else if (flags.lastLevel) begin
          stateNext = ST_FINISH;
        end else begin
          strobe.stepLevel = 1'b1;
          stateNext = ST_FETCH;
        end
      end
      ST_UPDATE: begin
        if (memReady) begin
          if (flags.lastLevel) begin
            stateNext = ST_FINISH;
          end else begin
            strobe.stepLevel = 1'b1;
            stateNext = ST_FETCH;
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memValid = (state == ST_FETCH) || (state == ST_UPDATE);
  assign memWrite = (state == ST_UPDATE);
  assign respValid = (state == ST_FINISH);
  assign respFault = faultQ;

  AST_UPDATE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UPDATE) |-> flags.present && !flags.denied && !flags.bigPage)
    else $error("write-back of a faulting descriptor"); // R10

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady) else $error("response not a single pulse"); // R11

  AST_HOLD_KIND: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memWrite)) else $error("request dropped"); // R12

endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PTE_W = 64,
  parameter int VA_W = OFF_W + LEVELS * IDX_W,
  parameter int PA_W = 52
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic [1:0]            reqAccess,
  input  logic                  reqUser,
  input  logic [PA_W-OFF_W-1:0] rootBase,
  output logic                  memValid,
  input  logic                  memReady,
  output logic                  memWrite,
  output logic [PA_W-1:0]       memAddr,
  output logic [PTE_W-1:0]      memWdata,
  input  logic                  memRvalid,
  input  logic [PTE_W-1:0]      memRdata,
  output logic                  respValid,
  output logic [PA_W-1:0]       respPaddr,
  output logic [1:0]            respFault
);

  strobe_t strobe;
  flags_t  flags;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReady(memReady), .memRvalid(memRvalid),
    .memValid(memValid), .memWrite(memWrite),
    .flags(flags), .strobe(strobe),
    .respValid(respValid), .respFault(respFault)
  );

  walk_dpath #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .PTE_W(PTE_W), .VA_W(VA_W), .PA_W(PA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqUser(reqUser),
    .rootBase(rootBase), .memRdata(memRdata), .flags(flags),
    .memAddr(memAddr), .memWdata(memWdata), .respPaddr(respPaddr)
  );

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> $stable(memAddr) && $stable(memWdata))
    else $error("request payload changed while stalled"); // R12

  AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite |-> memWdata[BIT_PRESENT] && memWdata[BIT_ACCESSED])
    else $error("write-back lacks present or accessed bit"); // R8

endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic [39:0] rootBase = 40'd1;
  logic        memValid, memWrite;
  logic        memReady = 1'b0;
  logic [51:0] memAddr;
  logic [63:0] memWdata;
  logic        memRvalid = 1'b0;
  logic [63:0] memRdata = '0;
  logic        respValid;
  logic [51:0] respPaddr;
  logic [1:0]  respFault;

  page_walker u_page_walker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqUser(reqUser), .rootBase(rootBase),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRdata(memRdata),
    .respValid(respValid), .respPaddr(respPaddr), .respFault(respFault)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] mem [0:4095];
  logic [51:0] expAddr [0:3];
  int readNum = 0;
  int writeNum = 0;
  int walkNum = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // memory responder, acting between clock edges
  logic [15:0] lfsr = 16'hACE1;
  int pend = 0;
  logic [11:0] pendIdx = '0;
  bit stall = 1'b0;
  logic [51:0] stallAddr = '0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memRvalid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        memRvalid = 1'b1;
        memRdata = mem[pendIdx];
      end
    end
    if (stall && rstN) begin
      check(memValid && memAddr == stallAddr, "R12", "stalled request held",
            64'(memAddr), 64'(stallAddr));
    end
    memReady = lfsr[0] | lfsr[3];
    if (rstN && memValid && memReady) begin
      check(memAddr[51:15] == '0, "R1", "address within table frames",
            64'(memAddr), 64'(memAddr[14:0]));
      if (memWrite) begin
        check(readNum > 0 && memAddr == expAddr[(readNum > 0) ? readNum - 1 : 0],
              "R8", "write-back address", 64'(memAddr),
              64'(expAddr[(readNum > 0) ? readNum - 1 : 0]));
        mem[memAddr[14:3]] = memWdata;
        writeNum++;
      end else begin
        check(readNum < 4 && memAddr == expAddr[(readNum < 4) ? readNum : 3],
              "R1", "descriptor read address", 64'(memAddr),
              64'(expAddr[(readNum < 4) ? readNum : 3]));
        pendIdx = memAddr[14:3];
        pend = 1 + int'(lfsr[5:4]) % 3;
        readNum++;
      end
    end
    stall = rstN && memValid && !memReady;
    stallAddr = memAddr;
  end

  function automatic logic [63:0] mkEntry(input logic [39:0] base, input logic [63:0] fl);
    return {12'h0, base, 12'h0} | fl;
  endfunction

  localparam logic [63:0] F_P = 64'h1;
  localparam logic [63:0] F_RW = 64'h2;
  localparam logic [63:0] F_US = 64'h4;
  localparam logic [63:0] F_A = 64'h20;
  localparam logic [63:0] F_D = 64'h40;
  localparam logic [63:0] F_PS = 64'h80;
  localparam logic [63:0] F_XD = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_OK = F_P | F_RW | F_US;

  task automatic runWalk(input int acc, input bit usr, input logic [63:0] f0,
                         input logic [63:0] f1, input logic [63:0] f2,
                         input logic [63:0] f3, input string tag);
    logic [63:0] fl [0:3];
    logic [63:0] e [0:3];
    logic [63:0] expE [0:3];
    logic [39:0] ptr [0:3];
    logic [39:0] tbl;
    logic [47:0] va;
    logic [1:0] expFault;
    int expReads, expWrites;
    bit rw, us, x, stop;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    va = {9'((walkNum * 37 + 5) % 512), 9'((walkNum * 101 + 17) % 512),
          9'((walkNum * 59 + 300) % 512), 9'((walkNum * 13 + 450) % 512),
          12'((walkNum * 331 + 7) % 4096)};
    ptr[0] = 40'd2; ptr[1] = 40'd3; ptr[2] = 40'd4;
    ptr[3] = 40'hA_BCDE_0000 + 40'(walkNum);
    for (int l = 0; l < 4; l++) begin
      tbl = (l == 0) ? 40'd1 : ptr[l-1];
      expAddr[l] = {tbl, va[47 - 9 * l -: 9], 3'b000};
      e[l] = mkEntry(ptr[l], fl[l]);
      expE[l] = e[l];
      mem[expAddr[l][14:3]] = e[l];
    end
    // reference model of the walk
    rw = 1; us = 1; x = 1; stop = 0;
    expFault = 2'd0; expReads = 0; expWrites = 0;
    for (int l = 0; l < 4; l++) begin
      if (!stop) begin
        expReads++;
        if (!e[l][0]) begin
          expFault = 2'd1; stop = 1;
        end else if (l == 0 && e[l][7]) begin
          expFault = 2'd3; stop = 1;
        end else begin
          rw = rw & e[l][1];
          us = us & e[l][2];
          x = x & !e[l][63];
          if ((acc == 1 && !rw) || (usr && !us) || (acc == 2 && !x)) begin
            expFault = 2'd2; stop = 1;
          end else begin
            logic [63:0] nw;
            nw = e[l] | F_A | ((l == 3 && acc == 1) ? F_D : 64'h0);
            if (nw != e[l]) begin
              expWrites++;
              expE[l] = nw;
            end
          end
        end
      end
    end
    readNum = 0;
    writeNum = 0;
    @(negedge clk);
    reqVaddr = va;
    reqAccess = 2'(acc);
    reqUser = usr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R11", "busy after accept", 64'(reqReady), 64'h0);
    while (!respValid) @(negedge clk);
    check(respFault == expFault, tag, "fault code", 64'(respFault), 64'(expFault));
    if (expFault == 2'd0)
      check(respPaddr == {e[3][51:12], va[11:0]}, "R2", "physical address",
            64'(respPaddr), 64'({e[3][51:12], va[11:0]}));
    @(negedge clk);
    check(!respValid && reqReady, "R11", "single response pulse then idle",
          64'({respValid, reqReady}), 64'h1);
    check(readNum == expReads, "R3", "descriptor reads", 64'(readNum), 64'(expReads));
    check(writeNum == expWrites, "R8", "write-backs", 64'(writeNum), 64'(expWrites));
    for (int l = 0; l < 4; l++)
      check(mem[expAddr[l][14:3]] == expE[l], "R8/R9/R10", "descriptor after walk",
            mem[expAddr[l][14:3]], expE[l]);
    walkNum++;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(reqReady && !memValid && !respValid, "R11", "reset state",
          64'({reqReady, memValid, respValid}), 64'h4);
    rstN = 1'b1;
    // permissive walks, accessed/dirty clear and already set
    for (int acc = 0; acc < 3; acc++)
      for (int usr = 0; usr < 2; usr++)
        for (int pre = 0; pre < 2; pre++) begin
          logic [63:0] f;
          f = F_OK | (pre != 0 ? (F_A | F_D) : 64'h0);
          runWalk(acc, usr[0], f, f, f, f, "R2");
        end
    // one restrictive level per walk, each kind of restriction
    for (int lvl = 0; lvl < 4; lvl++)
      for (int kind = 0; kind < 4; kind++)
        for (int acc = 0; acc < 3; acc++)
          for (int usr = 0; usr < 2; usr++) begin
            logic [63:0] f [0:3];
            string t;
            for (int l = 0; l < 4; l++) f[l] = F_OK;
            case (kind)
              0: begin f[lvl] = f[lvl] & ~F_P; t = "R3"; end
              1: begin f[lvl] = f[lvl] & ~F_RW; t = "R4"; end
              2: begin f[lvl] = f[lvl] & ~F_US; t = "R5"; end
              default: begin f[lvl] = f[lvl] | F_XD; t = "R6"; end
            endcase
            runWalk(acc, usr[0], f[0], f[1], f[2], f[3], t);
          end
    // large-page bit at each level
    for (int lvl = 0; lvl < 4; lvl++) begin
      logic [63:0] f [0:3];
      for (int l = 0; l < 4; l++) f[l] = F_OK;
      f[lvl] = f[lvl] | F_PS;
      runWalk(1, 1'b0, f[0], f[1], f[2], f[3], "R7");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule